// File: doc/BRIEF.md
# Trigger Control Receiver and Distributor

This block sits between the backplane clock-and-control card and the devices on a trigger processor board. It captures the 6-bit fast command and the 8-bit fast data word, each on its own one-cycle strobe. Each captured word is presented as a valid/ready stream to the board's command consumers. The four single-cycle timing pulses arrive on their own lines: bunch-zero, L1 accept, event-count reset and bunch-count reset. Each pulse is registered once and copied onto a dedicated flop for every device port.

A register-side port lets the bus interface inject test pulses, for example fake L1 accepts, to debug the readout path with no control card present. Each injected pulse is gated by its own enable bit and then ORed with the matching backplane pulse. The hard reset from the backplane is stretched to at least 12 cycles and driven to every device. The per-device configuration-done and active-low init lines are reduced to one done level and one init-error flag.

A watchdog counter, clocked by the on-board oscillator that runs this block, watches a toggle flop in the backplane clock domain. When no toggle arrives for 16 cycles, it declares the backplane clock lost. The clock-source select output then picks the oscillator, and the bus interface can also force that choice.

Both streams share the same back-pressure rules. A word is transferred on a cycle where valid and ready are both high. While ready is low, the held word and valid stay unchanged. A new strobe always replaces the held word, whether or not the old one was taken, so the latest word wins and the backplane is never stalled.

Top module: `ttc_distrib`

## Requirements
- R1: A command (data) strobe high at a clock edge loads the command (data) bus into the output word, and that stream's valid is high from the following cycle.
- R2: While valid is high, ready is low and no strobe arrives, valid and the word hold. A cycle with valid and ready high and no strobe clears valid at the next edge.
- R3: A strobe that arrives while a word is still pending overwrites it: the output shows only the newest word, and the overwritten word is never transferred.
- R4: Each timing pulse appears on the same output of every device port exactly one cycle after its input. The bit order of `inj_pulse` and `inj_en` is fixed: bit 0 bunch-zero, bit 1 L1 accept, bit 2 event-count reset, bit 3 bunch-count reset.
- R5: An injected pulse whose enable bit is 0 has no effect on any output. With its enable bit at 1, it is ORed with the backplane pulse of the same kind.
- R6: The hard-reset outputs of all devices rise one cycle after `bp_hard_rst` and stay high for exactly 12 cycles after a one-cycle input. For an input held L cycles, they stay high for L+11 cycles.
- R7: `cfg_done` is the AND of all `dev_done` bits and `init_err` is the OR of the inverted `dev_init_n` bits, each one cycle after the inputs.
- R8: `ext_lost` rises once `ext_clk` has stopped toggling for about 16 oscillator cycles (after the synchronizer). It falls again within a few cycles of toggles resuming.
- R9: `osc_sel` is high whenever `ext_lost` or `force_osc` is high, and low otherwise.
- R10: During reset, both valids and all timing outputs are low and every device reset output is high. The device reset outputs stay high for exactly 12 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-board oscillator clock running the block |
| rst_n | input | 1 | Active-low reset |
| ext_clk | input | 1 | Backplane 40 MHz clock, monitored only |
| bp_cmd | input | 6 | Backplane fast command bus |
| bp_cmd_stb | input | 1 | One-cycle command strobe |
| bp_data | input | 8 | Backplane fast data bus |
| bp_data_stb | input | 1 | One-cycle data strobe |
| bp_bx0 | input | 1 | Bunch-zero pulse |
| bp_l1a | input | 1 | L1 accept pulse |
| bp_evres | input | 1 | Event-count reset pulse |
| bp_bcres | input | 1 | Bunch-count reset pulse |
| bp_hard_rst | input | 1 | Backplane hard reset |
| cmd_word | output | 6 | Captured command word |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| data_word | output | 8 | Captured data word |
| data_valid | output | 1 | Data stream valid |
| data_ready | input | 1 | Data stream ready |
| inj_pulse | input | 4 | Register-side injected test pulses |
| inj_en | input | 4 | Per-source enables for injected pulses |
| force_osc | input | 1 | Force the oscillator as clock source |
| dev_done | input | 4 | Per-device configuration done |
| dev_init_n | input | 4 | Per-device init, active low |
| dev_bx0 | output | 4 | Bunch-zero per device |
| dev_l1a | output | 4 | L1 accept per device |
| dev_evres | output | 4 | Event-count reset per device |
| dev_bcres | output | 4 | Bunch-count reset per device |
| dev_rst | output | 4 | Stretched hard reset per device |
| cfg_done | output | 1 | All devices configured |
| init_err | output | 1 | Some device reports init low |
| ext_lost | output | 1 | Backplane clock declared lost |
| osc_sel | output | 1 | Clock source select, 1 = oscillator |

## Verification
The hardest state to reach from the ports is a lost backplane clock. Reaching it needs a second, asynchronous clock that stops long enough to run out the oscillator-side counter and then restarts. The bench drives `ext_clk` from its own generator with a run switch. It checks that `ext_lost` is still low partway through the gap, that it is high after the full count, and that it clears once toggling resumes. A pending word that is overwritten before the consumer accepts it is the other awkward case. The bench reaches it by holding ready low across two strobes, then checks that the scoreboard receives only the second word.

// File: rtl/ttc_pkg.sv
`timescale 1ns/1ps
package ttc_pkg;
  localparam int unsigned NPULSE = 4;
  // bit order of the pulse vectors; inj_pulse/inj_en follow it
  localparam int unsigned IX_BX0   = 0;
  localparam int unsigned IX_L1A   = 1;
  localparam int unsigned IX_EVRES = 2;
  localparam int unsigned IX_BCRES = 3;
  typedef logic [NPULSE-1:0] pulse_vec_t;
endpackage

// File: rtl/ttc_hold_reg.sv
`timescale 1ns/1ps
module ttc_hold_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (stb) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R1 capture on strobe (also covers the overwrite of R3)
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (valid && dout == $past(din)));
  // R2 hold under back-pressure
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !stb) |=> (valid && $stable(dout)));
  // R2 release after handshake
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !stb) |=> !valid);
endmodule

// File: rtl/ttc_pulse_fan.sv
`timescale 1ns/1ps
module ttc_pulse_fan
  import ttc_pkg::*;
#(
  parameter int unsigned NDEV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  pulse_vec_t                   bp_pulse,
  input  pulse_vec_t                   inj_pulse,
  input  pulse_vec_t                   inj_en,
  output logic [NPULSE-1:0][NDEV-1:0]  fan_o
);
  pulse_vec_t merged;
  assign merged = bp_pulse | (inj_pulse & inj_en);

  // one flop per device and pulse kind, to split the load
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    for (genvar p = 0; p < NPULSE; p++) begin : g_kind
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fan_o[p][d] <= 1'b0;
        else        fan_o[p][d] <= merged[p];
      end
    end
  end

  for (genvar p = 0; p < NPULSE; p++) begin : g_chk
    // R4 all device copies agree
    p_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fan_o[p] == '0) || (fan_o[p] == '1));
    // R4 a backplane pulse reaches the ports one cycle later
    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bp_pulse[p] |=> (fan_o[p] == '1));
    // R5 a disabled injection without a backplane pulse leaves outputs low
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_pulse[p] && !inj_en[p]) |=> (fan_o[p] == '0));
  end
endmodule

// File: rtl/ttc_rst_stretch.sv
`timescale 1ns/1ps
module ttc_rst_stretch #(
  parameter int unsigned NDEV    = 4,
  parameter int unsigned RST_CYC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hard_rst,
  output logic [NDEV-1:0] dev_rst
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= CW'(RST_CYC);
    else if (hard_rst)       remain <= CW'(RST_CYC);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign dev_rst = {NDEV{remain != '0}};

  // checker: length of the current high run
  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_len <= '0;
    else if (!dev_rst[0])        run_len <= '0;
    else if (run_len != CW'(RST_CYC)) run_len <= run_len + 1'b1;
  end

  // R6 reset follows the input
  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (dev_rst == '1));
  // R6 never shorter than the stretch length
  p_minlen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rst[0]) |-> (run_len == CW'(RST_CYC)));
endmodule

// File: rtl/ttc_clk_watch.sv
`timescale 1ns/1ps
module ttc_clk_watch #(
  parameter int unsigned LOST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic ext_lost
);
  localparam int unsigned CW = $clog2(LOST_CYC + 1);

  logic tog;
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {tog, s1, s2};
  end

  logic seen;
  assign seen = s2 ^ s3;

  logic [CW-1:0] idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idle <= '0;
    else if (seen)                  idle <= '0;
    else if (idle != CW'(LOST_CYC)) idle <= idle + 1'b1;
  end

  assign ext_lost = (idle == CW'(LOST_CYC));

  // R8 a toggle clears the loss flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> !ext_lost);
  // R8 loss persists while no toggle arrives
  p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lost && !seen) |=> ext_lost);
endmodule

// File: rtl/ttc_distrib.sv
`timescale 1ns/1ps
module ttc_distrib
  import ttc_pkg::*;
#(
  parameter int unsigned NDEV     = 4,
  parameter int unsigned CMD_W    = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RST_CYC  = 12,
  parameter int unsigned LOST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic [CMD_W-1:0]  bp_cmd,
  input  logic              bp_cmd_stb,
  input  logic [DATA_W-1:0] bp_data,
  input  logic              bp_data_stb,
  input  logic              bp_bx0,
  input  logic              bp_l1a,
  input  logic              bp_evres,
  input  logic              bp_bcres,
  input  logic              bp_hard_rst,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] data_word,
  output logic              data_valid,
  input  logic              data_ready,
  input  logic [3:0]        inj_pulse,
  input  logic [3:0]        inj_en,
  input  logic              force_osc,
  input  logic [NDEV-1:0]   dev_done,
  input  logic [NDEV-1:0]   dev_init_n,
  output logic [NDEV-1:0]   dev_bx0,
  output logic [NDEV-1:0]   dev_l1a,
  output logic [NDEV-1:0]   dev_evres,
  output logic [NDEV-1:0]   dev_bcres,
  output logic [NDEV-1:0]   dev_rst,
  output logic              cfg_done,
  output logic              init_err,
  output logic              ext_lost,
  output logic              osc_sel
);
  ttc_hold_reg #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .stb(bp_cmd_stb), .din(bp_cmd),
    .ready(cmd_ready), .valid(cmd_valid), .dout(cmd_word));

  ttc_hold_reg #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(bp_data_stb), .din(bp_data),
    .ready(data_ready), .valid(data_valid), .dout(data_word));

  pulse_vec_t bp_vec;
  always_comb begin
    bp_vec           = '0;
    bp_vec[IX_BX0]   = bp_bx0;
    bp_vec[IX_L1A]   = bp_l1a;
    bp_vec[IX_EVRES] = bp_evres;
    bp_vec[IX_BCRES] = bp_bcres;
  end

  logic [NPULSE-1:0][NDEV-1:0] fan;
  ttc_pulse_fan #(.NDEV(NDEV)) u_fan (
    .clk(clk), .rst_n(rst_n), .bp_pulse(bp_vec),
    .inj_pulse(inj_pulse), .inj_en(inj_en), .fan_o(fan));

  assign dev_bx0   = fan[IX_BX0];
  assign dev_l1a   = fan[IX_L1A];
  assign dev_evres = fan[IX_EVRES];
  assign dev_bcres = fan[IX_BCRES];

  ttc_rst_stretch #(.NDEV(NDEV), .RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .hard_rst(bp_hard_rst), .dev_rst(dev_rst));

  ttc_clk_watch #(.LOST_CYC(LOST_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_lost(ext_lost));

  assign osc_sel = ext_lost | force_osc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      init_err <= 1'b0;
    end else begin
      cfg_done <= &dev_done;
      init_err <= |(~dev_init_n);
    end
  end

  // R7 one missing done keeps the status low
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done != '1) |=> !cfg_done);
  // R7 any low init flags an error
  p_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_init_n != '1) |=> init_err);
  // R9 forcing always selects the oscillator
  p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_osc |-> osc_sel);
endmodule

// File: tb/ttc_distrib_test.sv
`timescale 1ns/1ps
module ttc_distrib_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic ext_run = 1'b1;
  logic [5:0] bp_cmd = '0;
  logic bp_cmd_stb = 1'b0;
  logic [7:0] bp_data = '0;
  logic bp_data_stb = 1'b0;
  logic bp_bx0 = 1'b0, bp_l1a = 1'b0, bp_evres = 1'b0, bp_bcres = 1'b0;
  logic bp_hard_rst = 1'b0;
  logic cmd_ready = 1'b1, data_ready = 1'b1;
  logic [3:0] inj_pulse = '0, inj_en = '0;
  logic force_osc = 1'b0;
  logic [3:0] dev_done = '0, dev_init_n = '1;
  logic [5:0] cmd_word;
  logic [7:0] data_word;
  logic cmd_valid, data_valid;
  logic [3:0] dev_bx0, dev_l1a, dev_evres, dev_bcres, dev_rst;
  logic cfg_done, init_err, ext_lost, osc_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [5:0] q_cmd[$];
  logic [7:0] q_data[$];
  logic [3:0] ex_pulse = '0;

  always #4 clk = ~clk;
  always begin
    #13;
    if (ext_run) ext_clk = ~ext_clk;
  end

  ttc_distrib uut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .bp_cmd(bp_cmd), .bp_cmd_stb(bp_cmd_stb), .bp_data(bp_data), .bp_data_stb(bp_data_stb),
    .bp_bx0(bp_bx0), .bp_l1a(bp_l1a), .bp_evres(bp_evres), .bp_bcres(bp_bcres),
    .bp_hard_rst(bp_hard_rst),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .data_word(data_word), .data_valid(data_valid), .data_ready(data_ready),
    .inj_pulse(inj_pulse), .inj_en(inj_en), .force_osc(force_osc),
    .dev_done(dev_done), .dev_init_n(dev_init_n),
    .dev_bx0(dev_bx0), .dev_l1a(dev_l1a), .dev_evres(dev_evres), .dev_bcres(dev_bcres),
    .dev_rst(dev_rst), .cfg_done(cfg_done), .init_err(init_err),
    .ext_lost(ext_lost), .osc_sel(osc_sel));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive point: just after the active edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: pushes the expected item into the scoreboard
  task automatic send_cmd(input logic [5:0] v, input bit push);
    bp_cmd = v; bp_cmd_stb = 1'b1;
    if (push) q_cmd.push_back(v);
    step();
    bp_cmd_stb = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] v);
    bp_data = v; bp_data_stb = 1'b1;
    q_data.push_back(v);
    step();
    bp_data_stb = 1'b0;
  endtask

  // expected pulse vector per R4/R5, one cycle behind the inputs
  always @(posedge clk) begin
    if (!rst_n) ex_pulse <= '0;
    else ex_pulse <= {bp_bcres, bp_evres, bp_l1a, bp_bx0} | (inj_pulse & inj_en);
  end

  // monitors: compare transfers and pulse outputs away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cmd_valid && cmd_ready) begin
        if (q_cmd.size() == 0) check(1'b0, "R1 cmd unexpected", int'(cmd_word), 0);
        else begin
          logic [5:0] e;
          e = q_cmd.pop_front();
          check(cmd_word == e, "R1/R3 cmd word", int'(cmd_word), int'(e));
        end
      end
      if (data_valid && data_ready) begin
        if (q_data.size() == 0) check(1'b0, "R1 data unexpected", int'(data_word), 0);
        else begin
          logic [7:0] e;
          e = q_data.pop_front();
          check(data_word == e, "R1 data word", int'(data_word), int'(e));
        end
      end
      check(dev_bx0   == {4{ex_pulse[0]}}, "R4 bx0 fanout",   int'(dev_bx0),   int'({4{ex_pulse[0]}}));
      check(dev_l1a   == {4{ex_pulse[1]}}, "R4 l1a fanout",   int'(dev_l1a),   int'({4{ex_pulse[1]}}));
      check(dev_evres == {4{ex_pulse[2]}}, "R4 evres fanout", int'(dev_evres), int'({4{ex_pulse[2]}}));
      check(dev_bcres == {4{ex_pulse[3]}}, "R4 bcres fanout", int'(dev_bcres), int'({4{ex_pulse[3]}}));
      check(osc_sel == (ext_lost | force_osc), "R9 osc_sel", int'(osc_sel), int'(ext_lost | force_osc));
    end
  end

  initial begin
    int n;
    repeat (3) step();
    // R10 reset state
    check(cmd_valid == 1'b0 && data_valid == 1'b0, "R10 valids in reset", int'({cmd_valid, data_valid}), 0);
    check(dev_rst == 4'hF, "R10 dev_rst in reset", int'(dev_rst), 15);
    check(dev_l1a == 4'h0, "R10 pulses in reset", int'(dev_l1a), 0);
    rst_n = 1'b1;
    n = 0;
    while (dev_rst != 4'h0 && n < 40) begin n++; step(); end
    check(n == 12, "R10 reset stretch after release", n, 12);

    // R1 command and data capture, ready high
    send_cmd(6'h2A, 1'b1);
    check(cmd_valid == 1'b1 && cmd_word == 6'h2A, "R1 cmd captured", int'(cmd_word), 'h2A);
    step();
    check(cmd_valid == 1'b0, "R2 cmd cleared after handshake", int'(cmd_valid), 0);
    send_data(8'hC3);
    check(data_valid == 1'b1 && data_word == 8'hC3, "R1 data captured", int'(data_word), 'hC3);
    send_data(8'h5A);
    step();

    // R2 hold under back-pressure, R3 overwrite
    cmd_ready = 1'b0;
    send_cmd(6'h11, 1'b0);
    repeat (3) step();
    check(cmd_valid == 1'b1 && cmd_word == 6'h11, "R2 held while not ready", int'(cmd_word), 'h11);
    send_cmd(6'h3C, 1'b1);
    check(cmd_word == 6'h3C, "R3 newest word wins", int'(cmd_word), 'h3C);
    cmd_ready = 1'b1;
    step();
    check(cmd_valid == 1'b0, "R2 released", int'(cmd_valid), 0);
    check(q_cmd.size() == 0, "R3 overwritten word never delivered", q_cmd.size(), 0);

    // R4 backplane pulses on every device port
    bp_l1a = 1'b1; step(); bp_l1a = 1'b0;
    check(dev_l1a == 4'hF, "R4 l1a on all ports", int'(dev_l1a), 15);
    bp_bx0 = 1'b1; bp_bcres = 1'b1; step(); bp_bx0 = 1'b0; bp_bcres = 1'b0;
    check(dev_bx0 == 4'hF && dev_bcres == 4'hF && dev_l1a == 4'h0, "R4 bx0+bcres",
          int'({dev_bx0, dev_bcres}), 'hFF);
    step();
    check(dev_bx0 == 4'h0, "R4 single-cycle width", int'(dev_bx0), 0);

    // R5 injection gated by enable
    inj_pulse = 4'b0010; inj_en = 4'b0000; step(); inj_pulse = '0;
    check(dev_l1a == 4'h0, "R5 disabled injection ignored", int'(dev_l1a), 0);
    inj_en = 4'b0010; inj_pulse = 4'b0010; step(); inj_pulse = '0;
    check(dev_l1a == 4'hF, "R5 enabled fake l1a", int'(dev_l1a), 15);
    inj_en = 4'b1111; inj_pulse = 4'b0100; bp_evres = 1'b1; step();
    inj_pulse = '0; bp_evres = 1'b0;
    check(dev_evres == 4'hF, "R5 injection ORed with backplane", int'(dev_evres), 15);
    inj_en = '0;
    step();

    // R6 hard reset stretch
    bp_hard_rst = 1'b1; step(); bp_hard_rst = 1'b0;
    n = 0;
    while (dev_rst != 4'h0 && n < 40) begin n++; step(); end
    check(n == 12, "R6 one-cycle reset stretched", n, 12);
    bp_hard_rst = 1'b1; step(); step(); step(); bp_hard_rst = 1'b0;
    n = 2;
    while (dev_rst != 4'h0 && n < 40) begin n++; step(); end
    check(n == 14, "R6 three-cycle reset", n, 14);

    // R7 status reduction
    dev_done = 4'hF; step();
    check(cfg_done == 1'b1, "R7 all done", int'(cfg_done), 1);
    dev_done = 4'hB; step();
    check(cfg_done == 1'b0, "R7 one not done", int'(cfg_done), 0);
    check(init_err == 1'b0, "R7 no init error", int'(init_err), 0);
    dev_init_n = 4'hD; step();
    check(init_err == 1'b1, "R7 init error", int'(init_err), 1);
    dev_init_n = 4'hF;

    // R8/R9 clock loss
    check(ext_lost == 1'b0 && osc_sel == 1'b0, "R8 clock present", int'(ext_lost), 0);
    force_osc = 1'b1; step();
    check(osc_sel == 1'b1, "R9 forced oscillator", int'(osc_sel), 1);
    force_osc = 1'b0;
    ext_run = 1'b0;
    repeat (10) step();
    check(ext_lost == 1'b0, "R8 not lost too early", int'(ext_lost), 0);
    repeat (20) step();
    check(ext_lost == 1'b1 && osc_sel == 1'b1, "R8 lost after gap", int'({ext_lost, osc_sel}), 3);
    ext_run = 1'b1;
    repeat (10) step();
    check(ext_lost == 1'b0 && osc_sel == 1'b0, "R8 recovered", int'({ext_lost, osc_sel}), 0);

    check(q_cmd.size() == 0 && q_data.size() == 0, "R1 scoreboard drained",
          q_cmd.size() + q_data.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule